// File: doc/BRIEF.md
# Single-cycle word load/store processor core

This block is a minimal 32-bit single-cycle processor core that executes only two instructions: the word load and the word store. In every clock cycle it presents its program counter on the instruction fetch port, takes the returned instruction word, pulls the register and immediate fields out of it, reads two operands from an internal 32-entry register file, and forms a byte address by adding a sign-extended immediate to the base register. A load returns the addressed data word into the destination register at the next rising edge. A store drives the second source register onto the data bus with the write strobe high.

Both memories sit outside the block. Instruction and data reads are combinational. The data store is expected to commit on the rising edge while the write strobe is high. Reset is synchronous and active high. While reset is high, the control path holds both the register write and the memory write low. This stops the instruction at address 0 from taking effect twice around reset release. Any instruction word that is not one of the two supported encodings passes through as a no-op.

Top module: `ldst_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0, and `imem_addr` reads 0 in the following cycle.
- R2: Outside reset, `imem_addr` increases by 4 at every rising edge, whatever instruction is being executed.
- R3: While `rst` is high, `dmem_we` is 0 and no register is written, even when the word at address 0 is a store.
- R4: An instruction with bits 6:0 = 7'b0000011 and bits 14:12 = 3'b010 is a word load. `dmem_addr` equals register[bits 19:15] plus the sign extension of bits 31:20. At the next rising edge, `dmem_rdata` is written into register[bits 11:7].
- R5: An instruction with bits 6:0 = 7'b0100011 and bits 14:12 = 3'b010 is a word store. `dmem_we` is 1, `dmem_wdata` equals register[bits 24:20], and `dmem_addr` equals register[bits 19:15] plus the sign extension of {bits 31:25, bits 11:7}.
- R6: Register 0 reads as zero on both operand paths, and a load that targets register 0 leaves it at zero.
- R7: Any other opcode, and either supported opcode with bits 14:12 other than 3'b010, writes neither memory nor a register.
- R8: Negative immediates of both formats produce base minus magnitude.
- R9: The word 0xfe042623 stores register 0 to register 8 minus 20. The word 0xfec42783 that follows loads that same word into register 15, which then holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address from the adder |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
The register file cannot be seen from the ports, so every register value that matters is loaded from preset data words and then stored back out, where it shows up on `dmem_wdata`. The hardest case is the reset window with a store at address 0. In that case the store has to stay silent for every cycle of reset and then fire exactly once after release. The bench places a store at address 0 over a sentinel data word and holds reset for several cycles. It checks that the sentinel survives the reset window and is overwritten only after release. It then asserts reset again part way through the program and observes the same gating.

// File: rtl/ldst_core.sv
module ldst_core #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [2:0] F3_WORD   = 3'b010;

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] rf [32];

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [4:0]  ra, rb, rd;
  logic [11:0] imm12;
  logic [XLEN-1:0] imm, opa, opb;
  logic        reg_we, mem_we, imm_sel_s;

  assign opc = imem_rdata[6:0];
  assign f3  = imem_rdata[14:12];
  assign ra  = imem_rdata[19:15];
  assign rb  = imem_rdata[24:20];
  assign rd  = imem_rdata[11:7];

  always_comb begin
    reg_we    = 1'b0;
    mem_we    = 1'b0;
    imm_sel_s = 1'b0;
    if (!rst && f3 == F3_WORD) begin
      case (opc)
        OPC_LOAD:  reg_we = 1'b1;
        OPC_STORE: begin mem_we = 1'b1; imm_sel_s = 1'b1; end
        default: ;
      endcase
    end
  end

  assign imm12 = imm_sel_s ? {imem_rdata[31:25], imem_rdata[11:7]} : imem_rdata[31:20];
  assign imm   = {{(XLEN-12){imm12[11]}}, imm12};

  assign opa = (ra == 5'd0) ? '0 : rf[ra];
  assign opb = (rb == 5'd0) ? '0 : rf[rb];

  assign dmem_addr  = opa + imm;
  assign dmem_wdata = opb;
  assign dmem_we    = mem_we;
  assign imem_addr  = pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc + XLEN'(4);
  end

  always_ff @(posedge clk) begin
    if (reg_we && rd != 5'd0) rf[rd] <= dmem_rdata;
  end
endmodule

// File: rtl/ldst_core_chk.sv
module ldst_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_rdata,
  input logic [XLEN-1:0] dmem_wdata,
  input logic            dmem_we
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

  AST_RST_NO_STORE: assert property (@(posedge clk) rst |-> !dmem_we); // R3
  AST_PC_ZERO_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && $past(rst)) |-> imem_addr == '0); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (seen_rst && !$past(rst)) |-> imem_addr == $past(imem_addr) + XLEN'(4)); // R2
  AST_STORE_ONLY_ON_SW: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (imem_rdata[6:0] == 7'b0100011 && imem_rdata[14:12] == 3'b010)); // R7
  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && imem_rdata[24:20] == 5'd0) |-> dmem_wdata == '0); // R6
endmodule

bind ldst_core ldst_core_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
  .dmem_wdata(dmem_wdata), .dmem_we(dmem_we)
);

// File: tb/ldst_core_tb.sv
module ldst_core_tb_top;
  logic clk = 0, rst = 1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  ldst_core dut_i (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_rdata(dmem_rdata));

  function automatic logic [31:0] enc_ld(int rd, int rs1, int imm);
    logic [11:0] i = 12'(imm);
    return {i, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] enc_st(int rs2, int rs1, int imm);
    logic [11:0] i = 12'(imm);
    return {i[11:5], 5'(rs2), 5'(rs1), 3'b010, i[4:0], 7'b0100011};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic        we;
    logic        ca;
    logic [31:0] addr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{enc_st(0,0,40),  1'b1, 1'b1, 32'h28, 32'h0},        // R6 store of x0, also first after reset
    '{enc_ld(8,0,0),   1'b0, 1'b1, 32'h00, 32'h0},        // R4 x8 = 0x80
    '{enc_ld(1,0,4),   1'b0, 1'b1, 32'h04, 32'h0},        // R4
    '{enc_ld(2,0,8),   1'b0, 1'b1, 32'h08, 32'h0},        // R4
    '{enc_st(1,8,16),  1'b1, 1'b1, 32'h90, 32'h12345678}, // R5
    '{enc_st(2,8,-4),  1'b1, 1'b1, 32'h7C, 32'hCAFEF00D}, // R8 negative S imm
    '{enc_ld(3,8,-4),  1'b0, 1'b1, 32'h7C, 32'h0},        // R8 negative I imm
    '{enc_st(3,0,12),  1'b1, 1'b1, 32'h0C, 32'hCAFEF00D}, // R4 load landed
    '{enc_ld(0,0,4),   1'b0, 1'b1, 32'h04, 32'h0},        // R6 load into x0
    '{enc_st(0,0,20),  1'b1, 1'b1, 32'h14, 32'h0},        // R6 x0 still zero
    '{32'h002082B3,    1'b0, 1'b0, 32'h0,  32'h0},        // R7 other opcode
    '{32'h00400183,    1'b0, 1'b0, 32'h0,  32'h0},        // R7 load, funct3 000
    '{32'h00100023,    1'b0, 1'b0, 32'h0,  32'h0},        // R7 store, funct3 000
    '{enc_st(3,0,24),  1'b1, 1'b1, 32'h18, 32'hCAFEF00D}, // R7 x3 untouched
    '{32'hfe042623,    1'b1, 1'b1, 32'h6C, 32'h0},        // R9
    '{32'hfec42783,    1'b0, 1'b1, 32'h6C, 32'h0},        // R9
    '{enc_st(15,0,28), 1'b1, 1'b1, 32'h1C, 32'h0}         // R9 x15 == 0
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    for (int i = 0; i < NV; i++) imem[i] = VEC[i].ins;
    dmem[0] = 32'h80; dmem[1] = 32'h12345678; dmem[2] = 32'hCAFEF00D;
    dmem[10] = 32'h55; dmem[27] = 32'hDEADBEEF;

    // reset window with a store at address 0
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); #1;
      if (c > 0) chk("R1 pc in reset", imem_addr, 32'h0);
      chk("R3 no store in reset", {31'b0, dmem_we}, 32'h0);
    end
    chk("R3 sentinel kept", dmem[10], 32'h55);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      #1;
      chk("R2 pc", imem_addr, 32'(4 * i));
      chk(VEC[i].we ? "R5 store strobe" : "R4/R7 no strobe", {31'b0, dmem_we}, {31'b0, VEC[i].we});
      if (VEC[i].ca) chk("R4/R5/R8 address", dmem_addr, VEC[i].addr);
      if (VEC[i].we) chk("R5/R6 store data", dmem_wdata, VEC[i].wd);
      @(negedge clk);
    end

    #1;
    chk("R5 sentinel replaced once", dmem[10], 32'h0);
    chk("R9 stored zero", dmem[27], 32'h0);
    chk("R5 stored word", dmem[36], 32'h12345678);
    chk("R7 unsupported is no-op", {31'b0, dmem_we}, 32'h0);

    // reset again mid-run
    rst = 1;
    dmem[10] = 32'h77;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      chk("R1 pc back to zero", imem_addr, 32'h0);
      chk("R3 store held off", {31'b0, dmem_we}, 32'h0);
    end
    chk("R3 sentinel kept mid-run", dmem[10], 32'h77);
    rst = 0; #1;
    chk("R5 store after release", {31'b0, dmem_we}, 32'h1);
    @(negedge clk); #1;
    chk("R2 step after release", imem_addr, 32'h4);
    chk("R5 single store", dmem[10], 32'h0);
    finish_run();
  end
endmodule